// File: doc/BRIEF.md
# Pulse-Train Burst Trigger

This block watches an uninterrupted stream of 14-bit converter samples, one per `sampleValid` strobe. It looks for a burst made of a fixed number of pulses, five by default, where each pulse has a width near 25 samples. When the last pulse of such a burst ends, it emits a one-cycle `trigger`. A capture engine downstream uses that pulse to start storing data at exactly that sample.

The raw word may arrive as two's complement or as offset binary. `offsetBinary` selects the coding. The block turns the word into two's complement and passes it out on `normSample`, delayed so that it lines up with `trigger`. A sample counts as "high" when its magnitude exceeds `threshold`. The accepted pulse width window and the longest allowed quiet gap between pulses are inputs. `arm` lets a capture in progress hold off new triggers, and detection carries on without a stop.

Top module: `pulse_train_trigger`

## Requirements
- R1: `normSample` equals `rawSample` with bit 13 inverted when `offsetBinary` is 1, and unchanged when it is 0. It appears with `normValid` high two clocks after the valid input sample, with one output per valid input, in order.
- R2: A sample is high only when the absolute value of its two's-complement form is strictly greater than `threshold`. A magnitude equal to `threshold` is low. Negative excursions count the same as positive ones.
- R3: A run of consecutive high samples counts as a pulse when its length L satisfies `minWidth` <= L <= `maxWidth`. A run outside that range clears the pulse count.
- R4: A run of low samples after a pulse keeps the count when its length is at most `maxGap`. The count is cleared on the low sample that makes the run one longer than `maxGap`.
- R5: `trigger` is high for exactly one cycle. That cycle is the one in which `normSample` carries the first low sample after the PULSES-th counted pulse.
- R6: While `arm` is low, the completing pulse raises no `trigger`, but the pulse count is still cleared.
- R7: Cycles with `sampleValid` low do not change the detection state, whatever `rawSample` carries.
- R8: `hunting` is 1 exactly when between 1 and PULSES-1 pulses have been counted. It is 0 in the trigger cycle.
- R9: During and after reset, `trigger`, `hunting` and `normValid` are 0.
- R10: After a trigger the detector starts over at once, and the next full burst triggers again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sampleValid | input | 1 | Marks a new sample on `rawSample` |
| rawSample | input | 14 | Converter word |
| offsetBinary | input | 1 | 1: word is offset binary; 0: two's complement |
| threshold | input | 14 | Magnitude a sample must exceed to be high |
| minWidth | input | 8 | Shortest accepted pulse, in samples |
| maxWidth | input | 8 | Longest accepted pulse, in samples |
| maxGap | input | 8 | Longest accepted low run between pulses (at least 1) |
| arm | input | 1 | Trigger enable; low while a capture is running |
| trigger | output | 1 | One-cycle mark of burst completion |
| hunting | output | 1 | A partial burst has been counted |
| normSample | output | 14 | Two's-complement sample, aligned with `trigger` |
| normValid | output | 1 | `normSample` carries a sample |

## Verification
The bench builds the block with its default parameters: 14-bit samples, 8-bit length counters and a five-pulse burst. At run time it sets a 20..30 sample width window, a gap limit of 10 and a threshold of 1000. With these values every edge case takes only a few hundred cycles to reach. These cases are widths of 19, 20, 30 and 31; gaps of 10 and 11; an amplitude equal to and one above the threshold; both input codings; and negative pulses. The same values also allow the expected trigger sample to be worked out directly from the burst layout the bench drives.

// File: rtl/ptt_pkg.sv
package ptt_pkg;
  // Per-sample strobes handed from the datapath to the control.
  typedef struct packed {
    logic valid;
    logic above;
  } sampleStrobe_t;
endpackage

// File: rtl/ptt_datapath.sv
module ptt_datapath
  import ptt_pkg::*;
#(
  parameter int SAMPLE_W = 14
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] rawSample,
  input  logic                offsetBinary,
  input  logic [SAMPLE_W-1:0] threshold,
  output sampleStrobe_t       strobe,
  output logic [SAMPLE_W-1:0] normSample,
  output logic                normValid
);
  localparam int MSB = SAMPLE_W - 1;

  logic [SAMPLE_W-1:0] normNow;
  logic [SAMPLE_W-1:0] magNow;
  logic [SAMPLE_W-1:0] s1Norm;
  logic                s1Valid;
  logic                s1Above;

  always_comb begin
    normNow = rawSample;
    if (offsetBinary) normNow[MSB] = ~rawSample[MSB];
    magNow = normNow[MSB] ? (~normNow + 1'b1) : normNow;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1Norm     <= '0;
      s1Valid    <= 1'b0;
      s1Above    <= 1'b0;
      normSample <= '0;
      normValid  <= 1'b0;
    end else begin
      s1Valid   <= sampleValid;
      normValid <= s1Valid;
      if (sampleValid) begin
        s1Norm  <= normNow;
        s1Above <= magNow > threshold;
      end
      if (s1Valid) normSample <= s1Norm;
    end
  end

  assign strobe.valid = s1Valid;
  assign strobe.above = s1Above;
endmodule

// File: rtl/ptt_control.sv
module ptt_control
  import ptt_pkg::*;
#(
  parameter int LEN_W  = 8,
  parameter int PULSES = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  sampleStrobe_t    strobe,
  input  logic             arm,
  input  logic [LEN_W-1:0] minWidth,
  input  logic [LEN_W-1:0] maxWidth,
  input  logic [LEN_W-1:0] maxGap,
  output logic             trigger,
  output logic             hunting
);
  localparam int CNT_W = $clog2(PULSES + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(PULSES - 1);
  localparam logic [LEN_W-1:0] LEN_MAX  = '1;

  logic [LEN_W-1:0] runLen;
  logic [LEN_W-1:0] gapLen;
  logic [CNT_W-1:0] pulseCnt;
  logic             widthOk;

  assign widthOk = (runLen >= minWidth) && (runLen <= maxWidth);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      runLen   <= '0;
      gapLen   <= '0;
      pulseCnt <= '0;
      trigger  <= 1'b0;
    end else begin
      trigger <= 1'b0;
      if (strobe.valid) begin
        if (strobe.above) begin
          if (runLen != LEN_MAX) runLen <= runLen + 1'b1;
          gapLen <= '0;
        end else if (runLen != '0) begin
          // first low sample: the pulse just ended
          runLen <= '0;
          gapLen <= LEN_W'(1);
          if (!widthOk) begin
            pulseCnt <= '0;
          end else if (pulseCnt == LAST_IDX) begin
            pulseCnt <= '0;
            trigger  <= arm;
          end else begin
            pulseCnt <= pulseCnt + 1'b1;
          end
        end else begin
          if (gapLen != LEN_MAX) gapLen <= gapLen + 1'b1;
          if (gapLen >= maxGap) pulseCnt <= '0;
        end
      end
    end
  end

  assign hunting = pulseCnt != '0;
endmodule

// File: rtl/pulse_train_trigger.sv
module pulse_train_trigger
  import ptt_pkg::*;
#(
  parameter int SAMPLE_W = 14,
  parameter int LEN_W    = 8,
  parameter int PULSES   = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] rawSample,
  input  logic                offsetBinary,
  input  logic [SAMPLE_W-1:0] threshold,
  input  logic [LEN_W-1:0]    minWidth,
  input  logic [LEN_W-1:0]    maxWidth,
  input  logic [LEN_W-1:0]    maxGap,
  input  logic                arm,
  output logic                trigger,
  output logic                hunting,
  output logic [SAMPLE_W-1:0] normSample,
  output logic                normValid
);
  sampleStrobe_t strobe;

  ptt_datapath #(.SAMPLE_W(SAMPLE_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .sampleValid(sampleValid), .rawSample(rawSample),
    .offsetBinary(offsetBinary), .threshold(threshold), .strobe(strobe),
    .normSample(normSample), .normValid(normValid)
  );

  ptt_control #(.LEN_W(LEN_W), .PULSES(PULSES)) ctl_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .arm(arm), .minWidth(minWidth),
    .maxWidth(maxWidth), .maxGap(maxGap), .trigger(trigger), .hunting(hunting)
  );
endmodule

// File: rtl/ptt_checker.sv
module ptt_checker (
  input logic clk,
  input logic rst_n,
  input logic arm,
  input logic trigger,
  input logic hunting,
  input logic normValid
);
  assert_trig_armed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trigger |-> $past(arm));
  assert_trig_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    trigger |=> !trigger);
  assert_trig_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
    trigger |-> normValid);
  assert_trig_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    trigger |-> !hunting);
  assert_reset_idle_R9: assert property (@(posedge clk)
    !rst_n |=> (!trigger && !hunting && !normValid));
endmodule

bind pulse_train_trigger ptt_checker chk_i (
  .clk(clk), .rst_n(rst_n), .arm(arm), .trigger(trigger),
  .hunting(hunting), .normValid(normValid)
);

// File: tb/pulse_train_trigger_tb_top.sv
module pulse_train_trigger_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sampleValid = 1'b0;
  logic [13:0] rawSample = '0;
  logic        offsetBinary = 1'b0;
  logic [13:0] threshold = 14'd1000;
  logic [7:0]  minWidth = 8'd20;
  logic [7:0]  maxWidth = 8'd30;
  logic [7:0]  maxGap = 8'd10;
  logic        arm = 1'b1;
  logic        trigger, hunting, normValid;
  logic [13:0] normSample;

  int checks = 0;
  int failures = 0;
  string curReq = "R1";
  logic [14:0] expQ[$];
  string reqQ[$];

  always #2.5 clk = ~clk;

  pulse_train_trigger dut_i (
    .clk(clk), .rst_n(rst_n), .sampleValid(sampleValid), .rawSample(rawSample),
    .offsetBinary(offsetBinary), .threshold(threshold), .minWidth(minWidth),
    .maxWidth(maxWidth), .maxGap(maxGap), .arm(arm), .trigger(trigger),
    .hunting(hunting), .normSample(normSample), .normValid(normValid)
  );

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // monitor: pops expected items as the design emits results
  always @(negedge clk) begin
    if (rst_n) begin
      if (normValid) begin
        if (expQ.size() == 0) begin
          check(0, "R1", "unexpected output", 1, 0);
        end else begin
          logic [14:0] e;
          string r;
          e = expQ.pop_front();
          r = reqQ.pop_front();
          check(normSample == e[13:0], "R1", "normSample", int'(normSample), int'(e[13:0]));
          check(trigger == e[14], r, "trigger", int'(trigger), int'(e[14]));
        end
      end else if (trigger) begin
        check(0, "R5", "trigger without normValid", 1, 0);
      end
    end
  end

  // driver
  task automatic sendVal(int val, bit expTrig);
    logic [13:0] v;
    v = 14'(val);
    rawSample   = offsetBinary ? (v ^ 14'h2000) : v;
    sampleValid = 1'b1;
    expQ.push_back({expTrig, v});
    reqQ.push_back(curReq);
    @(negedge clk);
    sampleValid = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      rawSample = 14'h1FFF;
      sampleValid = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic sendPulse(int width, int amp);
    for (int i = 0; i < width; i++) sendVal(amp, 1'b0);
  endtask

  task automatic sendGap(int len, bit trigFirst);
    for (int i = 0; i < len; i++) sendVal(0, trigFirst && i == 0);
  endtask

  task automatic burst(int width, int amp, int gap, bit expTrig);
    for (int p = 0; p < 5; p++) begin
      sendPulse(width, amp);
      sendGap(gap, expTrig && p == 4);
    end
  endtask

  task automatic flush();
    sendGap(15, 1'b0);
    idle(4);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!trigger && !hunting && !normValid, "R9", "reset outputs", int'({trigger, hunting, normValid}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    sendGap(3, 1'b0);

    curReq = "R5"; burst(25, 2000, 5, 1'b1);
    curReq = "R10"; burst(25, 2000, 5, 1'b1);
    flush();

    curReq = "R2"; burst(24, -3000, 6, 1'b1); flush();
    curReq = "R2"; burst(25, 1000, 5, 1'b0); flush();
    curReq = "R2"; burst(25, 1001, 5, 1'b1); flush();

    curReq = "R3";
    sendPulse(20, 2000); sendGap(5, 0); sendPulse(30, 2000); sendGap(5, 0);
    sendPulse(20, 2000); sendGap(5, 0); sendPulse(30, 2000); sendGap(5, 0);
    sendPulse(25, 2000); sendGap(5, 1); flush();
    sendPulse(25, 2000); sendGap(5, 0); sendPulse(25, 2000); sendGap(5, 0);
    sendPulse(19, 2000); sendGap(5, 0); sendPulse(25, 2000); sendGap(5, 0);
    sendPulse(25, 2000); sendGap(5, 0); flush();
    sendPulse(25, 2000); sendGap(5, 0); sendPulse(31, 2000); sendGap(5, 0);
    sendPulse(25, 2000); sendGap(5, 0); sendPulse(25, 2000); sendGap(5, 0);
    sendPulse(25, 2000); sendGap(5, 0); flush();

    curReq = "R4"; burst(25, 2000, 10, 1'b1); flush();
    sendPulse(25, 2000); sendGap(5, 0); sendPulse(25, 2000); sendGap(5, 0);
    sendPulse(25, 2000); sendGap(11, 0);
    sendPulse(25, 2000); sendGap(5, 0); sendPulse(25, 2000); sendGap(5, 0); flush();

    curReq = "R6"; arm = 1'b0;
    burst(25, 2000, 1, 1'b0);
    idle(4);
    check(hunting == 1'b0, "R6", "count cleared while disarmed", int'(hunting), 0);
    arm = 1'b1;
    for (int p = 0; p < 4; p++) begin sendPulse(25, 2000); sendGap(5, 0); end
    idle(4);
    check(hunting == 1'b1, "R8", "hunting after 4 pulses", int'(hunting), 1);
    sendPulse(25, 2000); sendGap(5, 1); flush();

    curReq = "R1"; offsetBinary = 1'b1;
    burst(25, 3000, 5, 1'b1);
    burst(25, -2500, 5, 1'b1);
    flush();
    offsetBinary = 1'b0;

    curReq = "R7";
    for (int p = 0; p < 5; p++) begin
      sendPulse(12, 2000); idle(3); sendPulse(13, 2000);
      idle(2);
      sendVal(0, p == 4); idle(5); sendGap(4, 0);
    end
    flush();

    curReq = "R8";
    sendPulse(25, 2000); sendGap(5, 0); sendPulse(25, 2000); sendGap(1, 0);
    idle(4);
    check(hunting == 1'b1, "R8", "hunting after 2 pulses", int'(hunting), 1);
    sendGap(11, 0); idle(4);
    check(hunting == 1'b0, "R8", "hunting after long gap", int'(hunting), 0);

    idle(6);
    check(expQ.size() == 0, "R1", "outputs outstanding", expQ.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL R5 watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule